// File: doc/BRIEF.md
# Configuration Window Address Translator

This block sits between a CPU-side strobe interface and a configuration-space responder. It watches every CPU access. When an access falls inside a fixed 4 MiB memory-mapped configuration window, the block turns it into one configuration-space request.

The device number is not taken from a binary address field. Eleven address lines above the offset bits each act as a one-hot select line. A priority scan picks the lowest select line that is set and turns its index into the device number. If no select line is set, the device number is the overflow value 11. The low eleven address bits pass through unchanged as the function and register offset. The device number is placed directly above them.

Each accepted access holds one request toward the responder until the responder acknowledges it. The block then gives the CPU a one-cycle acknowledge and, for reads, returns the data. The data is little-endian and sized to the access.

Top module: `cfg_window_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `cfg_req`, `cpu_ack` and `cpu_rdata` are all zero.
- R2: An access is accepted when it meets three conditions:
  - `cpu_req` is high while no request is outstanding;
  - `cpu_addr[31:22]` equals 10'h202 (window 0x8080_0000 to 0x80BF_FFFF);
  - `cpu_size` is not 3.
  An accepted access raises `cfg_req` in the next cycle and holds it until a cycle in which `cfg_ack` is high.
- R3: An access whose address lies outside the window, or whose `cpu_size` is 3, is ignored. `cfg_req` stays low and `cpu_ack` stays low.
- R4: The device number is the index (0 to 10) of the lowest set bit among `cpu_addr[21:11]`, where bit 11 is index 0.
- R5: When none of `cpu_addr[21:11]` is set, the device number is 11.
- R6: `cfg_addr` is 15 bits wide. It carries the device number in bits [14:11] and `cpu_addr[10:0]` unchanged in bits [10:0].
- R7: `cfg_we` and `cfg_size` repeat the access's `cpu_we` and `cpu_size`. The size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. `cfg_wdata` is `cpu_wdata` with every byte above the access size cleared.
- R8: `cfg_req` falls and `cpu_ack` is high in the cycle after `cfg_ack` is sampled high. `cpu_ack` lasts exactly one cycle.
- R9: During `cpu_ack` after a read, `cpu_rdata` is `cfg_rdata` (as sampled with `cfg_ack`) with the bytes above the access size set to zero. After a write, `cpu_rdata` is zero. When `cpu_ack` is low, `cpu_rdata` is zero.
- R10: A `cpu_req` that arrives while a request is outstanding is dropped, including in the cycle where `cfg_ack` is high. A `cpu_req` in the cycle where `cpu_ack` is high is accepted.
- R11: `cfg_addr`, `cfg_we`, `cfg_size` and `cfg_wdata` stay stable for as long as `cfg_req` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access strobe, one cycle per access |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 four bytes |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Write data, right-aligned, little-endian |
| cpu_ack | output | 1 | One-cycle completion pulse to the CPU |
| cpu_rdata | output | 32 | Read data, zero-extended to the access size |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_we | output | 1 | Request direction |
| cfg_size | output | 2 | Request size code |
| cfg_addr | output | 15 | Device number and function/register offset |
| cfg_wdata | output | 32 | Size-masked write data |
| cfg_ack | input | 1 | Responder acknowledge |
| cfg_rdata | input | 32 | Responder read data, valid with `cfg_ack` |

## Verification
The responder acknowledge and a new CPU strobe can land in the same cycle. The bench provokes this in two ways:
- It raises `cfg_ack` together with a second `cpu_req` to a different device. It then checks that the first access completes and that no second request appears in the following cycles.
- It drives a fresh strobe during the one-cycle `cpu_ack` pulse. It then checks that the new request rises one cycle later, with the new device number and offset.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    // Keep only the bytes covered by the access size.
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz,
                                                    input logic [DATA_W-1:0] val);
        logic [DATA_W-1:0] m;
        case (xfer_size_e'(sz))
            SZ_BYTE: m = {{(DATA_W-8){1'b0}},  8'hFF};
            SZ_HALF: m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: m = {DATA_W{1'b1}};
        endcase
        return val & m;
    endfunction

endpackage

// File: rtl/cfgx_devscan.sv
// Priority scan of one-hot select lines: the lowest set line wins.
// When no line is set, the result is SEL_LINES.
module cfgx_devscan #(
    parameter int SEL_LINES = 11,
    parameter int DEV_W     = $clog2(SEL_LINES + 1)
) (
    input  logic [SEL_LINES-1:0] sel,
    output logic [DEV_W-1:0]     dev
);
    always_comb begin
        dev = DEV_W'(SEL_LINES);
        for (int i = SEL_LINES - 1; i >= 0; i--) begin
            if (sel[i]) dev = DEV_W'(i);
        end
    end
endmodule

// File: rtl/cfgx_addr_map.sv
// Window decode and translation of a CPU address into a configuration address.
module cfgx_addr_map #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_BITS = 22,
    parameter int          OFS_BITS = 11,
    parameter int          DEV_W    = $clog2(WIN_BITS - OFS_BITS + 1)
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [OFS_BITS+DEV_W-1:0] xaddr
);
    localparam int SEL_LINES = WIN_BITS - OFS_BITS;

    logic [DEV_W-1:0] dev;

    assign hit = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    cfgx_devscan #(
        .SEL_LINES (SEL_LINES),
        .DEV_W     (DEV_W)
    ) u_scan (
        .sel (addr[WIN_BITS-1:OFS_BITS]),
        .dev (dev)
    );

    assign xaddr = {dev, addr[OFS_BITS-1:0]};
endmodule

// File: rtl/cfgx_ctrl.sv
// Single-outstanding request controller, two-process style.
module cfgx_ctrl
    import cfgx_pkg::*;
#(
    parameter int CFG_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic [CFG_AW-1:0] xaddr,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [1:0]        cfg_size,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_ack,
    input  logic [DATA_W-1:0] cfg_rdata
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [1:0]        size;
        logic [CFG_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     take;

    assign take = cpu_req && hit && (xfer_size_e'(cpu_size) != SZ_BAD);

    always_comb begin
        st_d       = st_q;
        st_d.ack   = 1'b0;
        st_d.rdata = '0;
        if (!st_q.busy) begin
            if (take) begin
                st_d.busy  = 1'b1;
                st_d.we    = cpu_we;
                st_d.size  = cpu_size;
                st_d.addr  = xaddr;
                st_d.wdata = size_mask(cpu_size, cpu_wdata);
            end
        end else if (cfg_ack) begin
            st_d.busy  = 1'b0;
            st_d.ack   = 1'b1;
            st_d.rdata = st_q.we ? '0 : size_mask(st_q.size, cfg_rdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_req   = st_q.busy;
    assign cfg_we    = st_q.we;
    assign cfg_size  = st_q.size;
    assign cfg_addr  = st_q.addr;
    assign cfg_wdata = st_q.wdata;
    assign cpu_ack   = st_q.ack;
    assign cpu_rdata = st_q.rdata;
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate #(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_BITS = 22,
    parameter int          OFS_BITS = 11
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              cpu_req,
    input  logic                                              cpu_we,
    input  logic [1:0]                                        cpu_size,
    input  logic [31:0]                                       cpu_addr,
    input  logic [31:0]                                       cpu_wdata,
    output logic                                              cpu_ack,
    output logic [31:0]                                       cpu_rdata,
    output logic                                              cfg_req,
    output logic                                              cfg_we,
    output logic [1:0]                                        cfg_size,
    output logic [OFS_BITS+$clog2(WIN_BITS-OFS_BITS+1)-1:0]   cfg_addr,
    output logic [31:0]                                       cfg_wdata,
    input  logic                                              cfg_ack,
    input  logic [31:0]                                       cfg_rdata
);
    localparam int DEV_W  = $clog2(WIN_BITS - OFS_BITS + 1);
    localparam int CFG_AW = OFS_BITS + DEV_W;

    logic              hit;
    logic [CFG_AW-1:0] xaddr;

    cfgx_addr_map #(
        .ADDR_W   (32),
        .WIN_BASE (WIN_BASE),
        .WIN_BITS (WIN_BITS),
        .OFS_BITS (OFS_BITS),
        .DEV_W    (DEV_W)
    ) u_map (
        .addr  (cpu_addr),
        .hit   (hit),
        .xaddr (xaddr)
    );

    cfgx_ctrl #(
        .CFG_AW (CFG_AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_size  (cpu_size),
        .cpu_wdata (cpu_wdata),
        .hit       (hit),
        .xaddr     (xaddr),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_size  (cfg_size),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_ack   (cfg_ack),
        .cfg_rdata (cfg_rdata)
    );
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_BITS = 22,
    parameter int          OFS_BITS = 11,
    parameter int          CFG_AW   = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [31:0]       cpu_addr,
    input logic              cpu_ack,
    input logic [31:0]       cpu_rdata,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [1:0]        cfg_size,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_ack
);
    logic in_win;
    assign in_win = (cpu_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req); // R2
    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req && cpu_req && !in_win |=> !cfg_req); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> cfg_addr[OFS_BITS-1:0] == $past(cpu_addr[OFS_BITS-1:0])); // R6
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_ack |=> !cfg_req && cpu_ack); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R8
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |-> cpu_rdata == 32'd0); // R9
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_we)
                                && $stable(cfg_size) && $stable(cfg_wdata)); // R11
endmodule

bind cfg_window_xlate cfgx_checker #(
    .WIN_BASE (WIN_BASE),
    .WIN_BITS (WIN_BITS),
    .OFS_BITS (OFS_BITS),
    .CFG_AW   (CFG_AW)
) u_chk (.*);

// File: tb/tb_cfg_window_xlate.sv
module tb_cfg_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        cfg_req, cfg_we;
    logic [1:0]  cfg_size;
    logic [14:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_vec = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    localparam logic [31:0] BASE = 32'h8080_0000;

    always #4 clk = ~clk;

    cfg_window_xlate dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 20000", cycles);
            finish_run();
        end
    end

    // Strobe one access; on return the request is expected to be visible.
    task automatic strobe(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd);
        cpu_req = 1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
    endtask

    // Full accepted access with the responder answering after `wait_n` cycles.
    task automatic access(input string req, input logic [31:0] a, input logic we,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [31:0] resp, input logic [3:0] exp_dev,
                          input logic [31:0] exp_wd, input logic [31:0] exp_rd,
                          input int wait_n);
        strobe(a, we, sz, wd);
        chk({req, " R2 req raised"}, 32'(cfg_req), 32'd1);
        chk({req, " R6 cfg_addr"}, 32'(cfg_addr), 32'({exp_dev, a[10:0]}));
        chk({req, " R7 we"}, 32'(cfg_we), 32'(we));
        chk({req, " R7 size"}, 32'(cfg_size), 32'(sz));
        chk({req, " R7 wdata"}, cfg_wdata, exp_wd);
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            chk({req, " R2 req held"}, 32'(cfg_req), 32'd1);
        end
        cfg_ack = 1; cfg_rdata = resp;
        @(negedge clk);
        cfg_ack = 0; cfg_rdata = '0;
        chk({req, " R8 req dropped"}, 32'(cfg_req), 32'd0);
        chk({req, " R8 cpu_ack"}, 32'(cpu_ack), 32'd1);
        chk({req, " R9 rdata"}, cpu_rdata, exp_rd);
        @(negedge clk);
        chk({req, " R8 ack one cycle"}, 32'(cpu_ack), 32'd0);
        chk({req, " R9 rdata idle"}, cpu_rdata, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cfg_req", 32'(cfg_req), 32'd0);
        chk("R1 cpu_ack", 32'(cpu_ack), 32'd0);
        chk("R1 cpu_rdata", cpu_rdata, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 cfg_req after release", 32'(cfg_req), 32'd0);
    endtask

    task automatic t_scan_single();
        for (int k = 0; k < 11; k++) begin
            logic [31:0] a;
            a = BASE | (32'd1 << (11 + k)) | 32'(k * 4 + 16);
            access("R4 one-hot", a, 1'b0, 2'd2, '0, 32'h0BAD_F00D, 4'(k),
                   32'd0, 32'h0BAD_F00D, k % 3);
        end
    endtask

    task automatic t_scan_multi();
        // bits 13 and 18 set: lowest is index 2
        access("R4 multi", BASE | (32'd1 << 13) | (32'd1 << 18) | 32'h3C, 1'b0, 2'd2,
               '0, 32'h1234_5678, 4'd2, 32'd0, 32'h1234_5678, 1);
        // bits 20 and 21: index 9
        access("R4 high pair", BASE | (32'd3 << 20) | 32'h7FC, 1'b0, 2'd2,
               '0, 32'h0000_0001, 4'd9, 32'd0, 32'h0000_0001, 0);
        // none set: overflow device
        access("R5 none", BASE | 32'h7FF, 1'b0, 2'd0, '0, 32'hFFFF_FFAB, 4'd11,
               32'd0, 32'h0000_00AB, 2);
    endtask

    task automatic t_sizes();
        access("R9 byte read", BASE | (32'd1 << 12) | 32'h1, 1'b0, 2'd0, '0,
               32'hA1B2_C3D4, 4'd1, 32'd0, 32'h0000_00D4, 0);
        access("R9 half read", BASE | (32'd1 << 12) | 32'h2, 1'b0, 2'd1, '0,
               32'hA1B2_C3D4, 4'd1, 32'd0, 32'h0000_C3D4, 0);
        access("R9 word read", BASE | (32'd1 << 12) | 32'h4, 1'b0, 2'd2, '0,
               32'hA1B2_C3D4, 4'd1, 32'd0, 32'hA1B2_C3D4, 0);
        access("R7 byte write", BASE | (32'd1 << 15) | 32'h8, 1'b1, 2'd0, 32'hDEAD_BEEF,
               32'h5555_5555, 4'd4, 32'h0000_00EF, 32'd0, 1);
        access("R7 half write", BASE | (32'd1 << 15) | 32'hA, 1'b1, 2'd1, 32'hDEAD_BEEF,
               32'h5555_5555, 4'd4, 32'h0000_BEEF, 32'd0, 0);
        access("R7 word write", BASE | (32'd1 << 15) | 32'hC, 1'b1, 2'd2, 32'hDEAD_BEEF,
               32'h5555_5555, 4'd4, 32'hDEAD_BEEF, 32'd0, 2);
    endtask

    task automatic ignored(input string req, input logic [31:0] a, input logic [1:0] sz);
        strobe(a, 1'b0, sz, 32'hFFFF_FFFF);
        for (int i = 0; i < 3; i++) begin
            chk({req, " no request"}, 32'(cfg_req), 32'd0);
            chk({req, " no ack"}, 32'(cpu_ack), 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_window();
        ignored("R3 below window", 32'h807F_FFFC, 2'd2);
        ignored("R3 above window", 32'h80C0_0000, 2'd2);
        ignored("R3 far outside", 32'h0080_0800, 2'd0);
        ignored("R3 bad size", BASE | (32'd1 << 11), 2'd3);
        access("R2 top of window", 32'h80BF_FFFC, 1'b0, 2'd2, '0, 32'h7777_0000,
               4'd0, 32'd0, 32'h7777_0000, 0);
        access("R2 bottom of window", BASE, 1'b0, 2'd2, '0, 32'h0000_8888,
               4'd11, 32'd0, 32'h0000_8888, 0);
    endtask

    task automatic t_collide();
        // second strobe lands together with the responder acknowledge: dropped
        strobe(BASE | (32'd1 << 14), 1'b0, 2'd2, '0);
        chk("R10 first req", 32'(cfg_req), 32'd1);
        cfg_ack = 1; cfg_rdata = 32'hCAFE_0001;
        cpu_req = 1; cpu_addr = BASE | (32'd1 << 17) | 32'h20; cpu_size = 2'd2; cpu_we = 0;
        @(negedge clk);
        cfg_ack = 0; cpu_req = 0; cfg_rdata = '0;
        chk("R10 first completes", 32'(cpu_ack), 32'd1);
        chk("R10 first rdata", cpu_rdata, 32'hCAFE_0001);
        chk("R10 collided strobe dropped", 32'(cfg_req), 32'd0);
        @(negedge clk);
        chk("R10 still no request", 32'(cfg_req), 32'd0);
        // strobe during the cpu_ack cycle: accepted
        strobe(BASE | (32'd1 << 16), 1'b0, 2'd2, '0);
        cfg_ack = 1; cfg_rdata = 32'hCAFE_0002;
        @(negedge clk);
        cfg_ack = 0; cfg_rdata = '0;
        chk("R10 setup ack", 32'(cpu_ack), 32'd1);
        strobe(BASE | (32'd1 << 19) | 32'h44, 1'b0, 2'd2, '0);
        chk("R10 strobe in ack cycle accepted", 32'(cfg_req), 32'd1);
        chk("R10 accepted addr", 32'(cfg_addr), 32'({4'd8, 11'h044}));
        cfg_ack = 1; cfg_rdata = 32'h0;
        @(negedge clk);
        cfg_ack = 0;
        @(negedge clk);
        chk("R10 quiet after", 32'(cfg_req), 32'd0);
    endtask

    initial begin
        t_reset();
        t_scan_single();
        t_scan_multi();
        t_sizes();
        t_window();
        t_collide();
        finish_run();
    end
endmodule